// File: doc/BRIEF.md
# Dual Converter Trigger Synchronizer

This block sits between a trigger fabric and two sample-converter front ends, a master and a slave. It decides what starts each converter and how their results are handed on. In free mode the two converters do not interact. Each one starts from its own selected trigger line and reports its own result with its own end-of-conversion pulse.

In parallel mode, one rising edge on the trigger line chosen by the master's select field starts both converters in the same cycle. The block then waits until both converters have signalled completion. After that it raises one sticky end-of-conversion flag and offers the two 16-bit results, packed into a single 32-bit word, on a valid/ready stream toward a DMA engine. The word is held until it is accepted. A new parallel conversion can start only after the word has been accepted.

The converters are modelled by a start pulse going out and a one-cycle done pulse with data coming back. The block also checks the pairing rules for parallel mode: the two converters must use the same sampling time and must not convert the same channel. It reports a breach of either rule on an error pin.

Top module: `dual_conv_sync`

## Requirements
- R1: In free mode (mode_par=0), a rising edge on trig_in[mst_sel] makes mst_start high for one cycle, in the cycle after the edge is sampled. A rising edge on trig_in[slv_sel] does the same for slv_start. Neither edge starts the other converter.
- R2: In free mode, a done pulse from a converter latches its data into that converter's rdata output. It also raises that converter's eoc output for the cycle after the done pulse. It leaves dma_valid and eoc_flag unchanged.
- R3: In parallel mode (mode_par=1), a rising edge on trig_in[mst_sel] raises mst_start and slv_start in the same cycle, one cycle after the edge. Edges on trig_in[slv_sel] start nothing, and no per-converter eoc pulse is produced.
- R4: In parallel mode, trigger edges that arrive after a launch start nothing until the packed word has been accepted.
- R5: In parallel mode, dma_valid and eoc_flag rise in the cycle after the later of the two done pulses, whichever converter finishes first or if both finish together. A single done pulse raises neither.
- R6: The packed word dma_data carries the slave result in bits 31:16 and the master result in bits 15:0.
- R7: Back-pressure: while dma_valid is high and dma_ready is low, dma_valid stays high and dma_data stays stable. After a cycle with dma_valid and dma_ready both high, dma_valid is low and the block accepts a new trigger.
- R8: eoc_flag is sticky. It clears on a clock edge where eoc_clr is high, and a completion on the same edge wins over the clear. irq equals eoc_flag AND (mst_ie OR slv_ie).
- R9: cfg_err is high when mode_par=1 and either mst_samp differs from slv_samp or mst_chan equals slv_chan. In free mode cfg_err is always low.
- R10: After reset, mst_start, slv_start, mst_eoc, slv_eoc, dma_valid, eoc_flag and irq are low, and mst_rdata, slv_rdata and dma_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_par | input | 1 | 0 = free mode, 1 = regular parallel mode |
| mst_sel | input | 3 | Master trigger line select |
| slv_sel | input | 3 | Slave trigger line select (used in free mode only) |
| trig_in | input | 8 | Trigger lines, rising edge = event |
| mst_samp | input | 3 | Master sampling-time setting |
| slv_samp | input | 3 | Slave sampling-time setting |
| mst_chan | input | 5 | Master channel number |
| slv_chan | input | 5 | Slave channel number |
| mst_ie | input | 1 | Interrupt enable, master side |
| slv_ie | input | 1 | Interrupt enable, slave side |
| eoc_clr | input | 1 | Write-1 clear of eoc_flag |
| mst_start | output | 1 | Start pulse to master converter |
| slv_start | output | 1 | Start pulse to slave converter |
| mst_done | input | 1 | Master conversion done pulse |
| slv_done | input | 1 | Slave conversion done pulse |
| mst_data | input | 16 | Master result, valid with mst_done |
| slv_data | input | 16 | Slave result, valid with slv_done |
| mst_rdata | output | 16 | Last master result |
| slv_rdata | output | 16 | Last slave result |
| mst_eoc | output | 1 | Free-mode master end-of-conversion pulse |
| slv_eoc | output | 1 | Free-mode slave end-of-conversion pulse |
| dma_valid | output | 1 | Packed word available |
| dma_ready | input | 1 | DMA accepts the packed word |
| dma_data | output | 32 | Packed result {slave, master} |
| eoc_flag | output | 1 | Sticky combined end-of-conversion status |
| irq | output | 1 | Interrupt request |
| cfg_err | output | 1 | Parallel-mode pairing rule broken |

## Verification
The internal state that can go wrong is the parallel sequencer's phase and its two completion markers. A sequencer stuck in its launch phase shows up one cycle after a trigger edge as a start pulse that should not be there. A lost or stale completion marker shows up one cycle after the later done pulse, as a missing or early dma_valid, or as a packed word with a half-word swapped or stale. A stall in the transfer phase shows up as dma_valid that stays high after the handshake cycle, followed by dead triggers.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  typedef enum logic {
    MODE_FREE = 1'b0,
    MODE_PAR  = 1'b1
  } sync_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CONV = 2'd1,
    S_XFER = 2'd2
  } pair_state_e;
endpackage

// File: rtl/dcs_trig_edge.sv
`timescale 1ns/1ps
module dcs_trig_edge #(
  parameter int N_TRIG = 8,
  localparam int SEL_W = $clog2(N_TRIG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  sel,
  output logic              rise
);
  // previous level kept per line, so a select change alone is no event
  logic [N_TRIG-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= trig_in;
  end

  assign rise = trig_in[sel] & ~prev_q[sel];
endmodule

// File: rtl/dcs_pair_seq.sv
`timescale 1ns/1ps
module dcs_pair_seq
  import dcs_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_par,
  input  logic              rise_m,
  input  logic              mst_done,
  input  logic              slv_done,
  input  logic [DATA_W-1:0] mst_data,
  input  logic [DATA_W-1:0] slv_data,
  input  logic              eoc_clr,
  input  logic              dma_ready,
  output logic              launch,
  output logic              dma_valid,
  output logic [WORD_W-1:0] dma_data,
  output logic              eoc_flag
);
  pair_state_e       state;
  logic              m_got, s_got;
  logic [DATA_W-1:0] m_buf, s_buf;
  logic              m_fin, s_fin, complete;

  assign launch   = (state == S_IDLE) && mode_par && rise_m;
  assign m_fin    = m_got | mst_done;
  assign s_fin    = s_got | slv_done;
  assign complete = (state == S_CONV) && m_fin && s_fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      m_got     <= 1'b0;
      s_got     <= 1'b0;
      m_buf     <= '0;
      s_buf     <= '0;
      dma_valid <= 1'b0;
      dma_data  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (launch) begin
            state <= S_CONV;
            m_got <= 1'b0;
            s_got <= 1'b0;
          end
        end
        S_CONV: begin
          if (mst_done && !m_got) begin
            m_got <= 1'b1;
            m_buf <= mst_data;
          end
          if (slv_done && !s_got) begin
            s_got <= 1'b1;
            s_buf <= slv_data;
          end
          if (complete) begin
            // slave in the upper half, master in the lower half
            dma_data  <= {(s_got ? s_buf : slv_data), (m_got ? m_buf : mst_data)};
            dma_valid <= 1'b1;
            state     <= S_XFER;
          end
        end
        S_XFER: begin
          if (dma_ready) begin
            dma_valid <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        eoc_flag <= 1'b0;
    else if (complete) eoc_flag <= 1'b1;
    else if (eoc_clr)  eoc_flag <= 1'b0;
  end

  // R7: stream word held under back-pressure
  p_dma_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_data)));

  // R5: a new word always comes with the combined flag
  p_word_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_valid) |-> eoc_flag);
endmodule

// File: rtl/dual_conv_sync.sv
`timescale 1ns/1ps
module dual_conv_sync
  import dcs_pkg::*;
#(
  parameter int N_TRIG = 8,
  parameter int DATA_W = 16,
  parameter int SAMP_W = 3,
  parameter int CHAN_W = 5,
  localparam int SEL_W  = $clog2(N_TRIG),
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_par,
  input  logic [SEL_W-1:0]  mst_sel,
  input  logic [SEL_W-1:0]  slv_sel,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SAMP_W-1:0] mst_samp,
  input  logic [SAMP_W-1:0] slv_samp,
  input  logic [CHAN_W-1:0] mst_chan,
  input  logic [CHAN_W-1:0] slv_chan,
  input  logic              mst_ie,
  input  logic              slv_ie,
  input  logic              eoc_clr,
  output logic              mst_start,
  output logic              slv_start,
  input  logic              mst_done,
  input  logic              slv_done,
  input  logic [DATA_W-1:0] mst_data,
  input  logic [DATA_W-1:0] slv_data,
  output logic [DATA_W-1:0] mst_rdata,
  output logic [DATA_W-1:0] slv_rdata,
  output logic              mst_eoc,
  output logic              slv_eoc,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [WORD_W-1:0] dma_data,
  output logic              eoc_flag,
  output logic              irq,
  output logic              cfg_err
);
  logic [1:0][SEL_W-1:0] sel_vec;
  logic [1:0]            rise;
  logic                  launch;
  sync_mode_e            mode;

  assign mode    = sync_mode_e'(mode_par);
  assign sel_vec = {slv_sel, mst_sel};

  // one edge detector per converter: index 0 master, 1 slave
  for (genvar g = 0; g < 2; g++) begin : g_edge
    dcs_trig_edge #(.N_TRIG(N_TRIG)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_in(trig_in),
      .sel    (sel_vec[g]),
      .rise   (rise[g])
    );
  end

  dcs_pair_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_par (mode_par),
    .rise_m   (rise[0]),
    .mst_done (mst_done),
    .slv_done (slv_done),
    .mst_data (mst_data),
    .slv_data (slv_data),
    .eoc_clr  (eoc_clr),
    .dma_ready(dma_ready),
    .launch   (launch),
    .dma_valid(dma_valid),
    .dma_data (dma_data),
    .eoc_flag (eoc_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_start <= 1'b0;
      slv_start <= 1'b0;
      mst_eoc   <= 1'b0;
      slv_eoc   <= 1'b0;
      mst_rdata <= '0;
      slv_rdata <= '0;
    end else begin
      if (mode == MODE_PAR) begin
        mst_start <= launch;
        slv_start <= launch;
      end else begin
        mst_start <= rise[0];
        slv_start <= rise[1];
      end
      mst_eoc <= (mode == MODE_FREE) && mst_done;
      slv_eoc <= (mode == MODE_FREE) && slv_done;
      if (mst_done) mst_rdata <= mst_data;
      if (slv_done) slv_rdata <= slv_data;
    end
  end

  assign irq     = eoc_flag & (mst_ie | slv_ie);
  assign cfg_err = (mode == MODE_PAR) && ((mst_samp != slv_samp) || (mst_chan == slv_chan));

  // R3: parallel launch reaches both converters together
  p_same_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_start && $past(mode_par)) |-> slv_start);

  // R4: no launch while a packed word waits
  p_no_start_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && mode_par) |=> !mst_start);

  // R8: interrupt only with the sticky flag
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> eoc_flag);
endmodule

// File: tb/dual_conv_sync_test.sv
`timescale 1ns/1ps
module dual_conv_sync_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_par = 1'b0;
  logic [2:0]  mst_sel = '0, slv_sel = '0;
  logic [7:0]  trig_in = '0;
  logic [2:0]  mst_samp = 3'd2, slv_samp = 3'd2;
  logic [4:0]  mst_chan = 5'd1, slv_chan = 5'd2;
  logic        mst_ie = 1'b0, slv_ie = 1'b0, eoc_clr = 1'b0;
  logic        mst_start, slv_start;
  logic        mst_done = 1'b0, slv_done = 1'b0;
  logic [15:0] mst_data = '0, slv_data = '0;
  logic [15:0] mst_rdata, slv_rdata;
  logic        mst_eoc, slv_eoc, dma_valid, eoc_flag, irq, cfg_err;
  logic        dma_ready = 1'b0;
  logic [31:0] dma_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dual_conv_sync uut (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .mst_sel(mst_sel), .slv_sel(slv_sel),
    .trig_in(trig_in), .mst_samp(mst_samp), .slv_samp(slv_samp), .mst_chan(mst_chan),
    .slv_chan(slv_chan), .mst_ie(mst_ie), .slv_ie(slv_ie), .eoc_clr(eoc_clr),
    .mst_start(mst_start), .slv_start(slv_start), .mst_done(mst_done), .slv_done(slv_done),
    .mst_data(mst_data), .slv_data(slv_data), .mst_rdata(mst_rdata), .slv_rdata(slv_rdata),
    .mst_eoc(mst_eoc), .slv_eoc(slv_eoc), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_data(dma_data), .eoc_flag(eoc_flag), .irq(irq), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] pack_word(logic [15:0] s, logic [15:0] m);
    return {s, m};
  endfunction

  function automatic logic exp_cfg(logic par, logic [2:0] sa, logic [2:0] sb,
                                   logic [4:0] ca, logic [4:0] cb);
    return par && ((sa != sb) || (ca == cb));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive a one-cycle high on a trigger line; report starts seen one cycle later
  task automatic pulse_trig(input int idx, output logic ms, output logic ss);
    @(negedge clk) trig_in[idx] = 1'b1;
    @(negedge clk);
    ms = mst_start;
    ss = slv_start;
    trig_in[idx] = 1'b0;
  endtask

  task automatic give_done(input logic m, input logic s, input logic [15:0] dm, input logic [15:0] ds);
    @(negedge clk);
    mst_done = m; slv_done = s; mst_data = dm; slv_data = ds;
    @(negedge clk);
    mst_done = 1'b0; slv_done = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk) eoc_clr = 1'b1;
    @(negedge clk) eoc_clr = 1'b0;
  endtask

  // hold ready low for 'wait_n' cycles, checking stability, then accept
  task automatic drain(input int wait_n, input logic [31:0] exp);
    for (int k = 0; k < wait_n; k++) begin
      @(negedge clk);
      chk(dma_valid === 1'b1, "R7 valid held", 32'(dma_valid), 32'd1);
      chk(dma_data === exp, "R7 data stable", dma_data, exp);
    end
    @(negedge clk) dma_ready = 1'b1;
    @(negedge clk) dma_ready = 1'b0;
    chk(dma_valid === 1'b0, "R7 valid cleared", 32'(dma_valid), 32'd0);
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ms, ss;
    logic [15:0] dm, ds;
    logic [31:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({mst_start, slv_start, mst_eoc, slv_eoc, dma_valid, eoc_flag, irq} === 7'b0,
        "R10 flags at reset", 32'({mst_start, slv_start, mst_eoc, slv_eoc, dma_valid, eoc_flag, irq}), 32'd0);
    chk({mst_rdata, slv_rdata} === 32'd0 && dma_data === 32'd0, "R10 data at reset", dma_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 free mode, independent triggers
    mode_par = 1'b0; mst_sel = 3'd2; slv_sel = 3'd5;
    pulse_trig(2, ms, ss);
    chk(ms === 1'b1 && ss === 1'b0, "R1 master only", 32'({ms, ss}), 32'b10);
    pulse_trig(5, ms, ss);
    chk(ms === 1'b0 && ss === 1'b1, "R1 slave only", 32'({ms, ss}), 32'b01);
    pulse_trig(7, ms, ss);
    chk(ms === 1'b0 && ss === 1'b0, "R1 unselected line", 32'({ms, ss}), 32'b00);

    // R2 free-mode results
    give_done(1'b1, 1'b0, 16'hA5C3, 16'h0);
    chk(mst_eoc === 1'b1 && slv_eoc === 1'b0, "R2 master eoc", 32'({mst_eoc, slv_eoc}), 32'b10);
    chk(mst_rdata === 16'hA5C3, "R2 master rdata", 32'(mst_rdata), 32'hA5C3);
    chk(dma_valid === 1'b0 && eoc_flag === 1'b0, "R2 no dma/flag", 32'({dma_valid, eoc_flag}), 32'd0);
    give_done(1'b0, 1'b1, 16'h0, 16'h3C5A);
    chk(slv_eoc === 1'b1 && slv_rdata === 16'h3C5A, "R2 slave eoc/rdata", 32'(slv_rdata), 32'h3C5A);

    // R9 configuration error
    chk(cfg_err === 1'b0, "R9 free mode no error", 32'(cfg_err), 32'd0);
    mode_par = 1'b1;
    @(negedge clk);
    chk(cfg_err === 1'b0, "R9 legal pair", 32'(cfg_err), 32'd0);
    slv_samp = 3'd5;
    @(negedge clk);
    chk(cfg_err === 1'b1, "R9 sample time mismatch", 32'(cfg_err), 32'd1);
    slv_samp = 3'd2; slv_chan = 5'd1;
    @(negedge clk);
    chk(cfg_err === 1'b1, "R9 same channel", 32'(cfg_err), 32'd1);
    slv_chan = 5'd2;
    for (int i = 0; i < 20; i++) begin
      logic [2:0] a, b; logic [4:0] c, d; logic p;
      a = 3'($urandom % 3); b = 3'($urandom % 3);
      c = 5'($urandom % 4); d = 5'($urandom % 4); p = 1'($urandom);
      mode_par = p; mst_samp = a; slv_samp = b; mst_chan = c; slv_chan = d;
      @(negedge clk);
      chk(cfg_err === exp_cfg(p, a, b, c, d), "R9 random config", 32'(cfg_err), 32'(exp_cfg(p, a, b, c, d)));
    end
    mode_par = 1'b1; mst_samp = 3'd2; slv_samp = 3'd2; mst_chan = 5'd1; slv_chan = 5'd2;

    // R3 parallel launch, slave select ignored
    mst_sel = 3'd3; slv_sel = 3'd6;
    pulse_trig(6, ms, ss);
    chk(ms === 1'b0 && ss === 1'b0, "R3 slave line ignored", 32'({ms, ss}), 32'b00);
    pulse_trig(3, ms, ss);
    chk(ms === 1'b1 && ss === 1'b1, "R3 joint start", 32'({ms, ss}), 32'b11);
    // R4 trigger during conversion
    pulse_trig(3, ms, ss);
    chk(ms === 1'b0 && ss === 1'b0, "R4 trigger while busy", 32'({ms, ss}), 32'b00);
    // R5 one done is not enough
    give_done(1'b1, 1'b0, 16'h1234, 16'h0);
    chk(dma_valid === 1'b0 && eoc_flag === 1'b0, "R5 half done", 32'({dma_valid, eoc_flag}), 32'd0);
    chk(mst_eoc === 1'b0, "R3 no per-converter eoc", 32'(mst_eoc), 32'd0);
    give_done(1'b0, 1'b1, 16'h0, 16'hBEEF);
    chk(dma_valid === 1'b1 && eoc_flag === 1'b1, "R5 both done", 32'({dma_valid, eoc_flag}), 32'b11);
    chk(dma_data === 32'hBEEF1234, "R6 packing", dma_data, 32'hBEEF1234);
    // R8 irq gating
    chk(irq === 1'b0, "R8 irq disabled", 32'(irq), 32'd0);
    slv_ie = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R8 irq via slave enable", 32'(irq), 32'd1);
    // R4 trigger during transfer
    pulse_trig(3, ms, ss);
    chk(ms === 1'b0, "R4 trigger while word pending", 32'(ms), 32'd0);
    drain(3, 32'hBEEF1234);
    chk(eoc_flag === 1'b1, "R8 flag sticky", 32'(eoc_flag), 32'd1);
    clear_flag();
    chk(eoc_flag === 1'b0 && irq === 1'b0, "R8 write-1 clear", 32'({eoc_flag, irq}), 32'd0);

    // R8 completion beats clear on the same edge
    pulse_trig(3, ms, ss);
    @(negedge clk);
    mst_done = 1'b1; slv_done = 1'b1; mst_data = 16'h0F0F; slv_data = 16'hF0F0; eoc_clr = 1'b1;
    @(negedge clk);
    mst_done = 1'b0; slv_done = 1'b0; eoc_clr = 1'b0;
    chk(eoc_flag === 1'b1, "R8 set wins over clear", 32'(eoc_flag), 32'd1);
    chk(dma_data === 32'hF0F00F0F, "R5 simultaneous done", dma_data, 32'hF0F00F0F);
    drain(0, 32'hF0F00F0F);
    clear_flag();

    // random parallel runs
    for (int i = 0; i < 40; i++) begin
      int sel, order;
      sel = int'($urandom % 8);
      mst_sel = 3'(sel); slv_sel = 3'(7 - sel);
      dm = 16'($urandom); ds = 16'($urandom);
      order = int'($urandom % 3);
      w = pack_word(ds, dm);
      pulse_trig(sel, ms, ss);
      chk(ms === 1'b1 && ss === 1'b1, "R3 random launch", 32'({ms, ss}), 32'b11);
      if (order == 0) begin
        give_done(1'b1, 1'b0, dm, 16'h0);
        chk(dma_valid === 1'b0, "R5 master first", 32'(dma_valid), 32'd0);
        give_done(1'b0, 1'b1, 16'h0, ds);
      end else if (order == 1) begin
        give_done(1'b0, 1'b1, 16'h0, ds);
        chk(dma_valid === 1'b0, "R5 slave first", 32'(dma_valid), 32'd0);
        give_done(1'b1, 1'b0, dm, 16'h0);
      end else begin
        give_done(1'b1, 1'b1, dm, ds);
      end
      chk(dma_valid === 1'b1 && eoc_flag === 1'b1, "R5 random complete", 32'({dma_valid, eoc_flag}), 32'b11);
      chk(dma_data === w, "R6 random packing", dma_data, w);
      drain(int'($urandom % 4), w);
      clear_flag();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule